// File: doc/BRIEF.md
# Page Write Sequencer with Self-Timed Programming Cycle

This block sits behind the serial front-end of a byte-wide nonvolatile store. When the front-end decodes a write-array command it hands over the starting address and a flag saying whether writing is allowed at that moment. Each following data byte arrives as a one-cycle strobe and lands in a 32-entry page buffer. The low five address bits advance after each byte and wrap inside the page. The upper bits stay fixed.

When the host raises chip select, the block decides whether to commit. It commits only if the serial bit counter sits exactly on a byte boundary and at least one data byte was taken. A commit starts a programming cycle of fixed length, counted in system clocks. While the cycle runs, the block replays the received page locations to the storage array in ascending offset order. It raises busy and forces the status byte to all ones. On the last cycle it pulses a clear to the write-enable latch.

Top module: `page_write_seq`

## Requirements
- R1: A data byte is written to an address whose bits above bit 4 equal those of the command address. Its bits 4..0 are the command's low five bits plus the number of earlier data bytes of that command, modulo 32.
- R2: When more than 32 data bytes are sent, the last byte sent to a page offset is the one written there.
- R3: A commit happens only if `cs_rise` arrives while `bit_aligned` is high and at least one data byte has been received. In every other case the buffer is dropped: no array write and no busy.
- R4: A write command that arrives with `wr_permit` low is ignored. Its bytes and the following select rise cause no array write and no busy.
- R5: Only page offsets that received a byte are written, one per clock, in ascending offset order. The writes start in the first busy cycle.
- R6: `busy` rises in the cycle after a committing `cs_rise` and stays high for exactly `CYCLE_CLKS` clocks.
- R7: `status_out` reads 8'hFF while `busy` is high and equals `status_in` otherwise.
- R8: `wel_clr` pulses for one clock in the last busy cycle of each programming cycle and at no other time.
- R9: Commands, data bytes and select rises that arrive while `busy` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wcmd_start | input | 1 | Write-array command and its address decoded (one-cycle pulse) |
| wcmd_addr | input | ADDR_W | Starting byte address of the command |
| wr_permit | input | 1 | Writing allowed, sampled with `wcmd_start` |
| data_vld | input | 1 | One data byte received (one-cycle pulse) |
| data_byte | input | 8 | Received data byte |
| cs_rise | input | 1 | Chip-select rising edge seen (one-cycle pulse) |
| bit_aligned | input | 1 | Serial bit counter is on a byte boundary |
| status_in | input | 8 | Status byte assembled by the register logic |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Programming cycle in progress |
| wel_clr | output | 1 | Clear pulse for the write-enable latch |
| status_out | output | 8 | Status byte as seen by the host |

## Verification
The hardest case to reach from the ports is the overflowing page. A write that starts near the top of a page must wrap past offset 31 and overwrite bytes it stored earlier in the same command. Only the final bytes at each offset may then reach the array, and they must appear in ascending order rather than in arrival order. The stimulus starts commands at offsets 30 and 0 and sends 3 and 34 bytes. A reference model in the bench predicts the exact write list. The same sequence is then ended on a misaligned select rise, with no bytes, and with writing not permitted. A full command is also sent during busy, so that every path that drops the buffer is exercised next to one that commits.

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BITS  = 5,
  parameter int CYCLE_CLKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wcmd_start,
  input  logic [ADDR_W-1:0] wcmd_addr,
  input  logic              wr_permit,
  input  logic              data_vld,
  input  logic [7:0]        data_byte,
  input  logic              cs_rise,
  input  logic              bit_aligned,
  input  logic [7:0]        status_in,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              wel_clr,
  output logic [7:0]        status_out
);
  localparam int PAGE = 1 << PAGE_BITS;
  localparam int TW   = $clog2(CYCLE_CLKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_PROG} st_t;

  st_t                       state;
  logic [ADDR_W-1:PAGE_BITS] page_q;
  logic [PAGE_BITS-1:0]      ptr;
  logic [PAGE-1:0]           mask;
  logic [7:0]                pbuf [PAGE];
  logic [TW-1:0]             timer;

  wire                 take_byte = (state == S_FILL) && !cs_rise && data_vld;
  wire [PAGE_BITS-1:0] scan      = timer[PAGE_BITS-1:0];
  wire                 in_scan   = (state == S_PROG) && (timer < TW'(PAGE));
  wire                 last_tick = (state == S_PROG) && (timer == TW'(CYCLE_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      page_q <= '0;
      ptr    <= '0;
      mask   <= '0;
      timer  <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (wcmd_start && wr_permit) begin
            state  <= S_FILL;
            page_q <= wcmd_addr[ADDR_W-1:PAGE_BITS];
            ptr    <= wcmd_addr[PAGE_BITS-1:0];
            mask   <= '0;
          end
        S_FILL:
          if (cs_rise) begin
            timer <= '0;
            if (bit_aligned && |mask) state <= S_PROG;
            else begin
              state <= S_IDLE;
              mask  <= '0;
            end
          end else if (data_vld) begin
            mask[ptr] <= 1'b1;
            ptr       <= ptr + 1'b1;
          end
        S_PROG:
          if (last_tick) begin
            state <= S_IDLE;
            mask  <= '0;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take_byte) pbuf[ptr] <= data_byte;
  end

  assign mem_we     = in_scan && mask[scan];
  assign mem_addr   = {page_q, scan};
  assign mem_wdata  = pbuf[scan];
  assign busy       = (state == S_PROG);
  assign wel_clr    = last_tick;
  assign status_out = busy ? 8'hFF : status_in;
endmodule

// File: rtl/page_write_seq_chk.sv
module page_write_seq_chk #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BITS  = 5,
  parameter int CYCLE_CLKS = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              wel_clr
);
  localparam int CW = $clog2(CYCLE_CLKS + 2);
  logic [CW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  a_r1_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr[ADDR_W-1:PAGE_BITS] == $past(mem_addr[ADDR_W-1:PAGE_BITS]));

  a_r5_offsets_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr[PAGE_BITS-1:0] > $past(mem_addr[PAGE_BITS-1:0]));

  a_r5_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r6_start_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  a_r6_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == CW'(CYCLE_CLKS));

  a_r8_clr_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> busy);

  a_r8_clr_ends_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy && !wel_clr);
endmodule

bind page_write_seq page_write_seq_chk #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .mem_we(mem_we),
  .mem_addr(mem_addr), .busy(busy), .wel_clr(wel_clr)
);

// File: tb/tb_page_write_seq.sv
`timescale 1ns/1ps
module tb_page_write_seq;
  localparam int AW  = 13;
  localparam int CYC = 40;

  logic clk = 0, rst_n = 0;
  logic wcmd_start = 0, wr_permit = 0, data_vld = 0, cs_rise = 0, bit_aligned = 0;
  logic [AW-1:0] wcmd_addr = '0;
  logic [7:0] data_byte = '0, status_in = 8'h5A;
  logic mem_we, busy, wel_clr;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, status_out;

  always #4 clk = ~clk;

  page_write_seq #(.ADDR_W(AW), .PAGE_BITS(5), .CYCLE_CLKS(CYC)) dut (
    .clk(clk), .rst_n(rst_n), .wcmd_start(wcmd_start), .wcmd_addr(wcmd_addr),
    .wr_permit(wr_permit), .data_vld(data_vld), .data_byte(data_byte),
    .cs_rise(cs_rise), .bit_aligned(bit_aligned), .status_in(status_in),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .wel_clr(wel_clr), .status_out(status_out));

  int total = 0, bad = 0;
  int busy_cnt = 0, clr_cnt = 0;
  logic [AW+7:0] expq [$];

  logic          m_act = 0;
  logic [AW-1:5] m_page;
  logic [4:0]    m_ptr;
  logic [31:0]   m_mask;
  logic [7:0]    m_buf [32];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (busy) begin
      busy_cnt++;
      check(status_out == 8'hFF, "R7 status during busy", status_out, 8'hFF);
    end else
      check(status_out == status_in, "R7 status passthrough", status_out, status_in);
    if (wel_clr) clr_cnt++;
    if (mem_we) begin
      if (expq.size() == 0)
        check(0, "R5 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [AW+7:0] e;
        e = expq.pop_front();
        check({mem_addr, mem_wdata} == e, "R1 R2 R5 write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic cmd(input logic [AW-1:0] a, input bit perm, input bit during_busy);
    step();
    wcmd_start = 1; wcmd_addr = a; wr_permit = perm;
    if (perm && !during_busy) begin
      m_act = 1; m_page = a[AW-1:5]; m_ptr = a[4:0]; m_mask = '0;
    end
    step();
    wcmd_start = 0; wr_permit = 0;
  endtask

  task automatic send(input logic [7:0] d);
    data_vld = 1; data_byte = d;
    if (m_act) begin
      m_buf[m_ptr] = d; m_mask[m_ptr] = 1'b1; m_ptr = m_ptr + 1'b1;
    end
    step();
    data_vld = 0;
  endtask

  task automatic finish_sel(input bit aligned, input string req);
    bit commit;
    commit = m_act && aligned && (m_mask != 0);
    if (commit)
      for (int i = 0; i < 32; i++)
        if (m_mask[i]) expq.push_back({m_page, 5'(i), m_buf[i]});
    m_act = 0;
    busy_cnt = 0; clr_cnt = 0;
    cs_rise = 1; bit_aligned = aligned;
    step();
    cs_rise = 0; bit_aligned = 0;
    #2 check(busy == commit, {req, " busy after select"}, busy, commit);
    if (commit) begin
      int guard = 0;
      while (busy && guard < 200) begin step(); guard++; end
    end else
      repeat (CYC + 5) step();
    @(negedge clk);
    check(busy_cnt == (commit ? CYC : 0), "R6 busy length", busy_cnt, commit ? CYC : 0);
    check(clr_cnt == (commit ? 1 : 0), "R8 wel_clr count", clr_cnt, commit ? 1 : 0);
    check(expq.size() == 0, {req, " writes outstanding"}, expq.size(), 0);
  endtask

  initial begin
    fork
      begin
        #3_000_000;
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check(busy == 0 && mem_we == 0 && wel_clr == 0, "R6 R8 reset state", {busy, mem_we, wel_clr}, 0);
    check(status_out == 8'h5A, "R7 reset status", status_out, 8'h5A);

    // R1 R5: plain four-byte write
    cmd(13'h0123, 1, 0);
    for (int i = 0; i < 4; i++) send(8'hA0 + 8'(i));
    finish_sel(1, "R1");

    // R1: wrap inside the page
    status_in = 8'h03;
    cmd(13'h1FFE, 1, 0);
    for (int i = 0; i < 3; i++) send(8'h10 + 8'(i));
    finish_sel(1, "R1 wrap");

    // R2: 34 bytes overwrite offsets 0 and 1
    cmd(13'h0400, 1, 0);
    for (int i = 0; i < 34; i++) send(8'(i * 3 + 1));
    finish_sel(1, "R2");

    // R3: misaligned select
    cmd(13'h0040, 1, 0);
    send(8'h77); send(8'h78);
    finish_sel(0, "R3 misaligned");

    // R3: no data bytes
    cmd(13'h0060, 1, 0);
    finish_sel(1, "R3 empty");

    // R4: not permitted
    cmd(13'h0080, 0, 0);
    send(8'h99); send(8'h9A);
    finish_sel(1, "R4");

    // R9: a command during busy has no effect
    cmd(13'h0200, 1, 0);
    send(8'hC1);
    for (int i = 0; i < 32; i++) expq.push_back({m_page, 5'(i), (i == 0) ? 8'hC1 : 8'h00});
    expq = {};
    expq.push_back({8'h10, 5'd0, 8'hC1});
    m_act = 0;
    busy_cnt = 0; clr_cnt = 0;
    cs_rise = 1; bit_aligned = 1; step(); cs_rise = 0; bit_aligned = 0;
    repeat (3) step();
    cmd(13'h0300, 1, 1);
    send(8'hEE);
    cs_rise = 1; bit_aligned = 1; step(); cs_rise = 0; bit_aligned = 0;
    repeat (CYC + 10) step();
    @(negedge clk);
    check(busy_cnt == CYC, "R9 single cycle length", busy_cnt, CYC);
    check(clr_cnt == 1, "R9 single wel_clr", clr_cnt, 1);
    check(expq.size() == 0, "R9 writes outstanding", expq.size(), 0);

    // R3: fresh command still works after discards
    cmd(13'h0555, 1, 0);
    send(8'h3C);
    finish_sel(1, "R3 recovery");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule